// File: doc/BRIEF.md
# Glitch-free two-input clock switch

This block picks one of two free-running clock sources that bear no phase or frequency relation to each other and drives a single output clock from it. A change of the select input never produces a runt pulse. The current path is first shut off cleanly. The output then rests low. The other path is enabled only after its own clock has been seen falling. The select input is expected to change at most once per 250 periods of the slower source, and the two sources may differ in frequency by up to ten times.

Each source owns an enable path. The path is a short synchronizer clocked on that source's falling edge, and it samples "selected and the other path is off". Because every enable changes while its own clock is low, the gated clocks can be merged with a plain OR. A source that stops must not lock the switch. So each path also watches how long it has waited for the other path to let go. After a fixed number of its own falling edges it clears the stuck path asynchronously, and the hand-over then proceeds.

Top module: `glitchless_clk_mux`

## Requirements
- R1: With `pick` low the output follows `src0_clk`; with `pick` high it follows `src1_clk`. Every output rising edge coincides with a rising edge of the selected source.
- R2: After `pick` changes, the output still shows two to three falling edges of the previously chosen source, and is then held low.
- R3: After the last output falling edge that comes from the old source, at least one and at most three falling edges of the new source pass before the output rises again.
- R4: Once a path is enabled, the output starts on a rising edge of the new source, and each high pulse equals that source's high time.
- R5: The output never shows a high or low pulse shorter than the narrower half-period of the two sources, and the two paths are never enabled together.
- R6: Selecting a source that has stopped parks the output low with no edges. When that source starts toggling, the output follows it without a further change of `pick`.
- R7: Leaving a source that has stopped, at either level, does not lock the switch. After `STALL_EDGES` (default 64) falling edges of the new source, the old path is cleared and the output follows the new source.
- R8: Hand-over obeys R2 to R4 when the two sources differ in frequency by close to a factor of ten.
- R9: While `rst_n` is low, both paths are disabled and the output is low. After release, the source named by `pick` is enabled through the normal sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src0_clk | input | 1 | Clock source chosen when `pick` is low |
| src1_clk | input | 1 | Clock source chosen when `pick` is high |
| pick | input | 1 | Source select, asynchronous to both sources |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_out | output | 1 | Switched output clock |

## Verification
Hand-overs are run in both directions, with a ratio of about 4.7 and then about 9.9 between the source periods. The bench counts old-source and new-source falling edges around each switch, which tells a correct hand-over sequence apart from one that is late, early or overlapping. A stopped target source shows whether the output parks low and later resumes on its own. A source stopped high while selected shows whether the release after a stall breaks the lockup that a plain cross-coupled switch would suffer. Throughout, every output pulse is timed, and the owner of each output rising edge is identified, so a glitch or the wrong source shows up at once.

// File: rtl/glitchless_clk_mux.sv
module glitchless_clk_mux #(
  parameter int SYNC_STAGES = 2,
  parameter int STALL_EDGES = 64
) (
  input  logic src0_clk,
  input  logic src1_clk,
  input  logic pick,
  input  logic rst_n,
  output logic clk_out
);
  localparam int CW = $clog2(STALL_EDGES + 1);
  localparam int MS = SYNC_STAGES - 1;

  logic [1:0] src, want, en, kill;

  assign src  = {src1_clk, src0_clk};
  assign want = {pick, ~pick};

  for (genvar g = 0; g < 2; g++) begin : g_path
    logic [MS:0]   chain;
    logic [MS:0]   wsync;
    logic [CW-1:0] cnt;
    logic          kill_q;
    logic          clr_n;

    assign clr_n = rst_n & ~kill[1-g];

    always_ff @(negedge src[g] or negedge clr_n)
      if (!clr_n) chain <= '0;
      else        chain <= {chain[MS-1:0], want[g] & ~en[1-g]};

    always_ff @(negedge src[g] or negedge rst_n)
      if (!rst_n) begin
        wsync  <= '0;
        cnt    <= '0;
        kill_q <= 1'b0;
      end else begin
        wsync <= {wsync[MS-1:0], want[g] & en[1-g]};
        if (!wsync[MS])                    cnt <= '0;
        else if (cnt != CW'(STALL_EDGES))  cnt <= cnt + 1'b1;
        kill_q <= wsync[MS] && (cnt == CW'(STALL_EDGES));
      end

    assign en[g]   = chain[MS];
    assign kill[g] = kill_q;
  end

  assign clk_out = |(src & en);
endmodule

// File: rtl/glitchless_clk_mux_chk.sv
module glitchless_clk_mux_chk #(
  parameter int STAGES = 2
) (
  input logic       src0_clk,
  input logic       src1_clk,
  input logic       pick,
  input logic       rst_n,
  input logic [1:0] en
);
  a_r5_exclusive: assert property (@(negedge src0_clk) disable iff (!rst_n)
    !(en[0] && en[1]));

  a_r2_leave0: assert property (@(negedge src0_clk) disable iff (!rst_n)
    $past(pick, STAGES) |-> !en[0]);

  a_r2_leave1: assert property (@(negedge src1_clk) disable iff (!rst_n)
    $past(!pick, STAGES) |-> !en[1]);

  a_r3_enter0: assert property (@(negedge src0_clk) disable iff (!rst_n)
    $rose(en[0]) |-> $past(!pick, STAGES));

  a_r3_enter1: assert property (@(negedge src1_clk) disable iff (!rst_n)
    $rose(en[1]) |-> $past(pick, STAGES));
endmodule

bind glitchless_clk_mux glitchless_clk_mux_chk #(.STAGES(SYNC_STAGES)) u_chk (
  .src0_clk(src0_clk),
  .src1_clk(src1_clk),
  .pick(pick),
  .rst_n(rst_n),
  .en(en)
);

// File: tb/glitchless_clk_mux_test.sv
`timescale 1ns/1ps
module glitchless_clk_mux_test;
  logic tb_clk = 1'b0;
  always #2.5 tb_clk = ~tb_clk;

  logic s0 = 1'b0, s1 = 1'b0, pick = 1'b0, rst_n = 1'b0;
  logic clk_out;

  glitchless_clk_mux uut (.src0_clk(s0), .src1_clk(s1), .pick(pick),
                          .rst_n(rst_n), .clk_out(clk_out));

  real h0 = 5.0, h1 = 23.7;
  bit run0 = 1'b1, run1 = 1'b1, park0 = 1'b0, park1 = 1'b0;
  realtime r0_rise = -1, r0_fall = -1, r1_rise = -1, r1_fall = -1;
  int fc0 = 0, fc1 = 0;

  always begin
    if (run0) begin
      #(h0); r0_rise = $realtime; s0 = 1'b1;
      #(h0); r0_fall = $realtime; fc0++; s0 = 1'b0;
    end else begin
      if (s0 !== park0) begin
        if (park0) r0_rise = $realtime;
        else begin r0_fall = $realtime; fc0++; end
        s0 = park0;
      end
      #1;
    end
  end

  always begin
    if (run1) begin
      #(h1); r1_rise = $realtime; s1 = 1'b1;
      #(h1); r1_fall = $realtime; fc1++; s1 = 1'b0;
    end else begin
      if (s1 !== park1) begin
        if (park1) r1_rise = $realtime;
        else begin r1_fall = $realtime; fc1++; end
        s1 = park1;
      end
      #1;
    end
  end

  int errors = 0, checks = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int fcnt(int i);
    return (i != 0) ? fc1 : fc0;
  endfunction

  function automatic real minh();
    return (h0 < h1) ? h0 : h1;
  endfunction

  int rc0 = 0, rc1 = 0, rcx = 0, glitches = 0;
  realtime t_edge = 0, hi_w = 0;
  bit trk = 1'b0, started = 1'b0;
  int hold = 0, hnew = 0, f_sw = 0, old_falls = -1, stop_new = 0, new_wait = -1;

  always @(posedge clk_out) begin
    int own;
    if ($realtime - t_edge < minh() - 0.001) glitches++;
    t_edge = $realtime;
    if ($realtime == r0_rise) begin rc0++; own = 0; end
    else if ($realtime == r1_rise) begin rc1++; own = 1; end
    else begin rcx++; own = 2; end
    if (trk && !started && own == hnew) begin
      started = 1'b1;
      new_wait = fcnt(hnew) - stop_new;
    end
  end

  always @(negedge clk_out) begin
    int own;
    hi_w = $realtime - t_edge;
    if (hi_w < minh() - 0.001) glitches++;
    t_edge = $realtime;
    if ($realtime == r0_fall) own = 0;
    else if ($realtime == r1_fall) own = 1;
    else own = 2;
    if (trk && !started && own == hold) begin
      old_falls = fcnt(hold) - f_sw;
      stop_new = fcnt(hnew);
    end
  end

  typedef struct {
    int      owner;
    realtime len;
    string   tag;
  } item_t;
  item_t q[$];

  initial begin
    forever begin
      item_t it;
      int a0, a1, ax, g, own, oth, expn;
      real h;
      wait (q.size() > 0);
      it = q.pop_front();
      a0 = rc0; a1 = rc1; ax = rcx; g = glitches;
      #(it.len);
      if (it.owner == 2) begin
        chk((rc0 - a0) + (rc1 - a1) + (rcx - ax) == 0, {it.tag, " no edges"},
            (rc0 - a0) + (rc1 - a1) + (rcx - ax), 0);
        chk(clk_out == 1'b0, {it.tag, " parked low"}, int'(clk_out), 0);
      end else begin
        h    = (it.owner != 0) ? h1 : h0;
        own  = (it.owner != 0) ? rc1 - a1 : rc0 - a0;
        oth  = ((it.owner != 0) ? rc0 - a0 : rc1 - a1) + (rcx - ax);
        expn = int'(it.len / (2.0 * h));
        chk(own >= expn - 1 && own <= expn + 1, {it.tag, " R1 edge count"}, own, expn);
        chk(oth == 0, {it.tag, " R1 foreign edges"}, oth, 0);
        chk(hi_w > h - 0.01 && hi_w < h + 0.01, {it.tag, " R4 high width ps"},
            int'(hi_w * 1000.0), int'(h * 1000.0));
      end
      chk(glitches == g, {it.tag, " R5 short pulses"}, glitches - g, 0);
    end
  end

  task automatic window(int owner, string tag);
    item_t it;
    it.owner = owner; it.len = 20000.0; it.tag = tag;
    q.push_back(it);
    #22500;
  endtask

  task automatic switch_to(bit nsel);
    hold = int'(pick); hnew = int'(nsel);
    f_sw = fcnt(hold); old_falls = -1; new_wait = -1; started = 1'b0;
    trk = 1'b1;
    pick = nsel;
  endtask

  task automatic handover(string tag);
    chk(old_falls >= 2 && old_falls <= 3, {tag, " R2 old falls"}, old_falls, 2);
    chk(new_wait >= 1 && new_wait <= 3, {tag, " R3 new falls held low"}, new_wait, 2);
    trk = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge tb_clk);
    errors++; checks++;
    $display("FAIL watchdog: run did not complete, actual=0 expected=1");
    finish_run();
  end

  initial begin
    int hi_in_rst = 0;
    repeat (40) @(negedge tb_clk) if (clk_out) hi_in_rst++;
    chk(hi_in_rst == 0, "R9 output low in reset", hi_in_rst, 0);
    rst_n = 1'b1;
    #3000;
    window(0, "R9 after reset");

    switch_to(1'b1); #3000; handover("R1 to src1");
    window(1, "R1 src1");
    switch_to(1'b0); #3000; handover("R1 to src0");
    window(0, "R1 src0");

    h1 = 49.3;
    #2000;
    switch_to(1'b1); #3000; handover("R8 to slow");
    window(1, "R8 slow src1");
    switch_to(1'b0); #3000; handover("R8 to fast");
    window(0, "R8 fast src0");

    run1 = 1'b0; park1 = 1'b0;
    #1000;
    switch_to(1'b1); #3000;
    chk(old_falls >= 2 && old_falls <= 3, "R6 old falls before park", old_falls, 2);
    trk = 1'b0;
    window(2, "R6 dead target");
    run1 = 1'b1;
    #3000;
    window(1, "R6 resumed");

    park1 = 1'b1; run1 = 1'b0;
    #2000;
    chk(clk_out == 1'b1, "R7 stuck-high source shown", int'(clk_out), 1);
    switch_to(1'b0); #5000; trk = 1'b0;
    window(0, "R7 released");
    park1 = 1'b0; run1 = 1'b1;
    #2000;
    switch_to(1'b1); #3000; handover("R7 back to src1");
    window(1, "R7 src1 reusable");

    finish_run();
  end
endmodule